// File: doc/BRIEF.md
# Dual-Channel 7:1 Pixel Serializer for Flat-Panel Links

This block turns a 24-bit RGB pixel stream into the serial bit streams that drive a two-channel flat-panel link. Each pixel is captured whole, together with its horizontal sync, vertical sync and data-enable bits. Consecutive pixels are grouped into pairs. The first pixel of a pair goes to channel A and the second to channel B. Each pixel becomes four 7-bit lane words, and the words are shifted out one bit per lane on every edge of a bit clock that runs at 3.5 times the pixel clock. One pair is therefore sent every seven bit clocks.

Each channel also has a clock lane. The clock lane is not a divided clock. It is the fixed word 1100011 sent through the same kind of shift register as the data, so its 4/7 high time and its edges line up with the data word boundaries. Pairing restarts at every rising edge of data enable, so the first active pixel of a line always lands on channel A. The outputs are single-ended; differential buffers and the clock source sit outside the block.

Top module: `lvds_dual_ser`

## Requirements
- R1: Each lane sends one 7-bit word every seven bit clocks, most significant bit first, and the word boundary falls on the same bit clock on all ten lanes.
- R2: Both clock lanes repeat the word 1100011, most significant bit first, on the same word boundary as the data. The two clock lanes are identical at every bit clock.
- R3: The first pixel of a pair is sent on data lanes 0–3 (channel A). The second pixel of the pair is sent on data lanes 4–7 (channel B), with the same lane order within the channel.
- R4: Within a channel, with r, g and b the 8-bit colour fields of `rgb_i` (bits 23:16, 15:8 and 7:0), the words sent most significant bit first are:
  - lane 0: {g0, r5..r0}
  - lane 1: {b1, b0, g5..g1}
  - lane 2: {de, vsync, hsync, b5..b2}
  - lane 3: {0, b7, b6, g7, g6, r7, r6}
- R5: All colour and control bits of one pixel, including red bits 6 and 7, appear in the same word period. No field lags the others by a pixel.
- R6: A rising edge of `de_i` makes that pixel the first of a new pair. A pixel held waiting for a partner at that moment is dropped. A pair is sent only once both of its pixels have been captured.
- R7: Every complete pair appears on the lanes exactly once and in order. At a word boundary where no new pair is ready, the previous pair is sent again.
- R8: While `rst_ni` is low, all data lanes are low and both clock lanes keep sending the 1100011 pattern.
- R9: With the bit clock at 3.5 times the pixel clock, the block keeps up with an unbroken pixel stream; no pair is lost and the backlog never grows beyond the pipeline depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pix_i | input | 1 | Pixel clock |
| clk_bit_i | input | 1 | Bit clock at 3.5 times the pixel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rgb_i | input | 24 | Pixel colour, red 23:16, green 15:8, blue 7:0 |
| hsync_i | input | 1 | Horizontal sync |
| vsync_i | input | 1 | Vertical sync |
| de_i | input | 1 | Data enable |
| data_o | output | 8 | Serial data lanes; 0–3 channel A, 4–7 channel B |
| clk_lane_o | output | 2 | Serial clock lanes; bit 0 channel A, bit 1 channel B |

## Verification
The bench rebuilds words from the serial lanes, using the clock-lane pattern to find word boundaries, and matches them pair by pair against a model of the pairing rule.

It targets the following corner cases:

| Corner case | What a faulty design does |
|---|---|
| One-pixel and odd-length lines, where data enable rises while a pixel is held | Pushes every later pixel onto the wrong channel |
| The word boundary left without a fresh pair after such a restart | Sends a blank pair, or shifts the stream, instead of repeating the last pair |
| Pixels with only the top red bits set | Exposes a red field that trails the other bits by a pixel |
| Reset | Shows a silent or stuck clock lane, or non-zero data lanes |

// File: rtl/lvds_ser_pkg.sv
package lvds_ser_pkg;
  parameter int unsigned COLOR_W      = 8;
  parameter int unsigned WORD_W       = 7;
  parameter int unsigned LANES_PER_CH = 4;
  parameter int unsigned NUM_CH       = 2;

  localparam int unsigned NUM_LANES = LANES_PER_CH * NUM_CH;
  localparam int unsigned RGB_W     = 3 * COLOR_W;
  localparam logic [WORD_W-1:0] CLK_WORD = 7'b1100011;

  typedef struct packed {
    logic [COLOR_W-1:0] r;
    logic [COLOR_W-1:0] g;
    logic [COLOR_W-1:0] b;
    logic               hs;
    logic               vs;
    logic               de;
  } pixel_t;

  typedef logic [LANES_PER_CH-1:0][WORD_W-1:0] ch_words_t;
  typedef logic [NUM_CH-1:0][LANES_PER_CH-1:0][WORD_W-1:0] pair_words_t;

  // lane word layout, bit 6 leaves first
  function automatic ch_words_t pack_pixel(input pixel_t p);
    ch_words_t w;
    w[0] = {p.g[0], p.r[5:0]};
    w[1] = {p.b[1:0], p.g[5:1]};
    w[2] = {p.de, p.vs, p.hs, p.b[5:2]};
    w[3] = {1'b0, p.b[7:6], p.g[7:6], p.r[7:6]};
    return w;
  endfunction
endpackage

// File: rtl/lvds_pair_hold.sv
module lvds_pair_hold
  import lvds_ser_pkg::*;
(
  input  logic        clk_pix_i,
  input  logic        rst_ni,
  input  pixel_t      pix_i,
  output pair_words_t pair_o,
  output logic        pair_tgl_o
);
  logic        de_q;
  logic        phase_q;   // 1: first pixel of pair is held
  ch_words_t   first_q;
  pair_words_t pair_q;
  logic        tgl_q;
  logic        de_rise;
  ch_words_t   cur_w;

  assign de_rise = pix_i.de & ~de_q;
  assign cur_w   = pack_pixel(pix_i);

  always_ff @(posedge clk_pix_i or negedge rst_ni) begin
    if (!rst_ni) begin
      de_q    <= 1'b0;
      phase_q <= 1'b0;
      first_q <= '0;
      pair_q  <= '0;
      tgl_q   <= 1'b0;
    end else begin
      de_q <= pix_i.de;
      if (de_rise || !phase_q) begin
        // line start drops any held partner
        first_q <= cur_w;
        phase_q <= 1'b1;
      end else begin
        pair_q[0] <= first_q;
        pair_q[1] <= cur_w;
        tgl_q     <= ~tgl_q;
        phase_q   <= 1'b0;
      end
    end
  end

  assign pair_o     = pair_q;
  assign pair_tgl_o = tgl_q;
endmodule

// File: rtl/lvds_pair_sync.sv
module lvds_pair_sync
  import lvds_ser_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk_bit_i,
  input  logic        rst_ni,
  input  pair_words_t pair_i,
  input  logic        pair_tgl_i,
  output pair_words_t stage_o
);
  logic [SYNC_STAGES:0] sync_q;
  pair_words_t          stage_q;
  logic                 fresh;

  assign fresh = sync_q[SYNC_STAGES] ^ sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_bit_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= '0;
      stage_q <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-1:0], pair_tgl_i};
      // pair_i is stable for seven bit clocks around the toggle
      if (fresh) stage_q <= pair_i;
    end
  end

  assign stage_o = stage_q;
endmodule

// File: rtl/lvds_word_ctr.sv
module lvds_word_ctr #(
  parameter int unsigned WORD_W = 7
) (
  input  logic clk_i,
  output logic load_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0] cnt_q;

  // no reset: clock lanes must run through reset; out-of-range states self-clear
  always_ff @(posedge clk_i) begin
    cnt_q <= (cnt_q >= LAST) ? '0 : cnt_q + CNT_W'(1);
  end

  assign load_o = (cnt_q == LAST);
endmodule

// File: rtl/lvds_lane_ser.sv
module lvds_lane_ser #(
  parameter int unsigned WORD_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              bit_o
);
  logic [WORD_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sr_q <= '0;
    else if (load_i) sr_q <= word_i;
    else             sr_q <= {sr_q[WORD_W-2:0], 1'b0};
  end

  assign bit_o = sr_q[WORD_W-1];
endmodule

// File: rtl/lvds_dual_ser.sv
module lvds_dual_ser
  import lvds_ser_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk_pix_i,
  input  logic                 clk_bit_i,
  input  logic                 rst_ni,
  input  logic [RGB_W-1:0]     rgb_i,
  input  logic                 hsync_i,
  input  logic                 vsync_i,
  input  logic                 de_i,
  output logic [NUM_LANES-1:0] data_o,
  output logic [NUM_CH-1:0]    clk_lane_o
);
  pixel_t      pix;
  pair_words_t pair;
  pair_words_t stage;
  logic        pair_tgl;
  logic        load;

  assign pix.r  = rgb_i[3*COLOR_W-1 -: COLOR_W];
  assign pix.g  = rgb_i[2*COLOR_W-1 -: COLOR_W];
  assign pix.b  = rgb_i[COLOR_W-1:0];
  assign pix.hs = hsync_i;
  assign pix.vs = vsync_i;
  assign pix.de = de_i;

  lvds_pair_hold u_hold (
    .clk_pix_i  (clk_pix_i),
    .rst_ni     (rst_ni),
    .pix_i      (pix),
    .pair_o     (pair),
    .pair_tgl_o (pair_tgl)
  );

  lvds_pair_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_bit_i  (clk_bit_i),
    .rst_ni     (rst_ni),
    .pair_i     (pair),
    .pair_tgl_i (pair_tgl),
    .stage_o    (stage)
  );

  lvds_word_ctr #(.WORD_W(WORD_W)) u_ctr (
    .clk_i  (clk_bit_i),
    .load_o (load)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    for (genvar l = 0; l < LANES_PER_CH; l++) begin : g_lane
      lvds_lane_ser #(.WORD_W(WORD_W)) u_lane (
        .clk_i  (clk_bit_i),
        .rst_ni (rst_ni),
        .load_i (load),
        .word_i (stage[c][l]),
        .bit_o  (data_o[c*LANES_PER_CH+l])
      );
    end

    // clock lane: constant word through the same shift path, unreset
    logic [WORD_W-1:0] ck_sr_q;
    always_ff @(posedge clk_bit_i) begin
      ck_sr_q <= load ? CLK_WORD : {ck_sr_q[WORD_W-2:0], 1'b0};
    end
    assign clk_lane_o[c] = ck_sr_q[WORD_W-1];
  end
endmodule

// File: rtl/lvds_dual_ser_chk.sv
module lvds_dual_ser_chk
  import lvds_ser_pkg::*;
(
  input logic                 clk_pix_i,
  input logic                 clk_bit_i,
  input logic                 rst_ni,
  input logic                 de_i,
  input logic                 pair_tgl,
  input logic                 load,
  input logic [NUM_LANES-1:0] data_o,
  input logic [NUM_CH-1:0]    clk_lane_o
);
  logic [3:0] since_q;
  logic       seen_q;
  logic [2:0] hi_q, lo_q;
  logic       de_prev_q;

  always_ff @(posedge clk_bit_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_q <= '0;
      seen_q  <= 1'b0;
      hi_q    <= '0;
      lo_q    <= '0;
    end else begin
      if (load) begin
        since_q <= '0;
        seen_q  <= 1'b1;
      end else if (since_q != 4'hf) begin
        since_q <= since_q + 4'd1;
      end
      hi_q <= clk_lane_o[0] ? ((hi_q == 3'd7) ? hi_q : hi_q + 3'd1) : 3'd0;
      lo_q <= clk_lane_o[0] ? 3'd0 : ((lo_q == 3'd7) ? lo_q : lo_q + 3'd1);
    end
  end

  always_ff @(posedge clk_pix_i or negedge rst_ni) begin
    if (!rst_ni) de_prev_q <= 1'b0;
    else         de_prev_q <= de_i;
  end

  assert_reload_period_R1: assert property (@(posedge clk_bit_i) disable iff (!rst_ni)
    (load && seen_q) |-> (since_q == 4'd6));

  assert_clk_lanes_match_R2: assert property (@(posedge clk_bit_i) disable iff (!rst_ni)
    clk_lane_o[0] == clk_lane_o[1]);

  assert_clk_high_run_R2: assert property (@(posedge clk_bit_i) disable iff (!rst_ni)
    clk_lane_o[0] |-> (hi_q < 3'd4));

  assert_clk_low_run_R2: assert property (@(posedge clk_bit_i) disable iff (!rst_ni)
    !clk_lane_o[0] |-> (lo_q < 3'd3));

  assert_no_pair_on_rise_R6: assert property (@(posedge clk_pix_i) disable iff (!rst_ni)
    (de_i && !de_prev_q) |=> $stable(pair_tgl));

  assert_pair_after_rise_R6: assert property (@(posedge clk_pix_i) disable iff (!rst_ni)
    (de_i && !de_prev_q) |-> ##2 !$stable(pair_tgl));

  assert_pair_spacing_R9: assert property (@(posedge clk_pix_i) disable iff (!rst_ni)
    !$stable(pair_tgl) |=> $stable(pair_tgl));

  always @(posedge clk_bit_i) begin
    if (!rst_ni) begin
      assert_data_low_R8: assert (data_o == '0);
    end
  end
endmodule

bind lvds_dual_ser lvds_dual_ser_chk u_chk (
  .clk_pix_i  (clk_pix_i),
  .clk_bit_i  (clk_bit_i),
  .rst_ni     (rst_ni),
  .de_i       (de_i),
  .pair_tgl   (pair_tgl),
  .load       (load),
  .data_o     (data_o),
  .clk_lane_o (clk_lane_o)
);

// File: tb/lvds_dual_ser_bench.sv
`timescale 1ns/1ps
module lvds_dual_ser_bench;
  logic        clk_pix = 1'b0;
  logic        clk_bit = 1'b0;
  logic        rst_ni  = 1'b0;
  logic [23:0] rgb = '0;
  logic        hs = 1'b0, vs = 1'b0, de = 1'b0;
  logic [7:0]  data;
  logic [1:0]  clk_lane;

  int n_cmp = 0;
  int n_bad = 0;

  logic [55:0] exp_q [0:4095];
  int          wr = 0;
  int          rd = 0;

  // pairing model state
  bit          m_de = 1'b0;
  bit          m_ph = 1'b0;
  logic [27:0] m_first = '0;

  // deserializer state
  logic [6:0]  clk_h = '0, clk1_h = '0;
  logic [6:0]  dat_h [0:7];
  int          since = 0;
  bit          bnd_seen = 1'b0;
  int          rst_bnd = 0;
  logic [55:0] last_w = '0;

  lvds_dual_ser u_lvds_dual_ser (
    .clk_pix_i  (clk_pix),
    .clk_bit_i  (clk_bit),
    .rst_ni     (rst_ni),
    .rgb_i      (rgb),
    .hsync_i    (hs),
    .vsync_i    (vs),
    .de_i       (de),
    .data_o     (data),
    .clk_lane_o (clk_lane)
  );

  always #10 clk_pix = ~clk_pix;

  // bit clock: 7 cycles per 40 ns, edges placed on an absolute grid
  initial begin : bit_gen
    longint n;
    longint t_cur;
    longint t_nxt;
    n = 0;
    t_cur = 0;
    #1;
    forever begin
      n++;
      t_nxt = (n * 40000) / 14;
      #(real'(t_nxt - t_cur) / 1000.0);
      t_cur = t_nxt;
      clk_bit = ~clk_bit;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  // expected lane words of one pixel (R4 layout)
  function automatic logic [27:0] bpack(input logic [23:0] c, input logic h,
                                        input logic v, input logic d);
    logic [7:0] r, g, b;
    logic [6:0] w0, w1, w2, w3;
    r = c[23:16];
    g = c[15:8];
    b = c[7:0];
    w0 = {g[0], r[5], r[4], r[3], r[2], r[1], r[0]};
    w1 = {b[1], b[0], g[5], g[4], g[3], g[2], g[1]};
    w2 = {d, v, h, b[5], b[4], b[3], b[2]};
    w3 = {1'b0, b[7], b[6], g[7], g[6], r[7], r[6]};
    return {w3, w2, w1, w0};
  endfunction

  task automatic drive(input logic [23:0] c, input logic h, input logic v, input logic d);
    @(negedge clk_pix);
    rgb = c; hs = h; vs = v; de = d;
    rst_ni = 1'b1;
    // R6 model: a rising de starts a new pair
    if ((d && !m_de) || !m_ph) begin
      m_first = bpack(c, h, v, d);
      m_ph = 1'b1;
    end else begin
      exp_q[wr] = {bpack(c, h, v, d), m_first};  // R3: first pixel on lanes 0-3
      wr++;
      m_ph = 1'b0;
    end
    m_de = d;
  endtask

  task automatic line(input int blank_n, input int act_n);
    for (int i = 0; i < blank_n; i++)
      drive($urandom, 1'($urandom), 1'($urandom), 1'b0);
    for (int i = 0; i < act_n; i++)
      drive($urandom, 1'($urandom), 1'($urandom), 1'b1);
  endtask

  initial begin
    for (int l = 0; l < 8; l++) dat_h[l] = '0;
  end

  always @(negedge clk_bit) begin : deser
    logic [55:0] dec;
    clk_h  = {clk_h[5:0], clk_lane[0]};
    clk1_h = {clk1_h[5:0], clk_lane[1]};
    for (int l = 0; l < 8; l++) dat_h[l] = {dat_h[l][5:0], data[l]};
    since++;
    if (!rst_ni) chk(data == 8'h00, "R8", "data lanes in reset", 64'(data), 64'h0);
    if (clk_h == 7'b1100011) begin
      if (!rst_ni) rst_bnd++;
      chk(clk1_h == 7'b1100011, "R2", "channel B clock word", 64'(clk1_h), 64'h63);
      if (bnd_seen) chk(since == 7, "R1", "bits between word boundaries", 64'(since), 64'd7);
      bnd_seen = 1'b1;
      since = 0;
      for (int l = 0; l < 8; l++) dec[l*7 +: 7] = dat_h[l];
      if (dec != last_w) begin
        // R3 R4 R5 R6 R7: next fresh word must be the next expected pair
        if (rd < wr) begin
          chk(dec == exp_q[rd], "R7", "pair words (R3/R4/R5/R6)", 64'(dec), 64'(exp_q[rd]));
          rd++;
        end else begin
          chk(1'b0, "R7", "unexpected pair", 64'(dec), 64'(last_w));
        end
        last_w = dec;
      end
    end
  end

  initial begin
    void'($urandom(32'h1d5a_0c37));
    repeat (12) @(negedge clk_pix);
    chk(rst_bnd >= 3, "R8", "clock word boundaries seen in reset", 64'(rst_bnd), 64'd3);

    // directed: one-pixel and odd lines (R6 restart with dropped partner)
    line(1, 1);
    line(1, 1);
    line(2, 3);
    line(1, 2);
    line(3, 5);
    // directed: top red bits alone and with all others (R5)
    drive(24'hC0_00_00, 1'b0, 1'b0, 1'b1);
    drive(24'h3F_FF_FF, 1'b1, 1'b1, 1'b1);
    drive(24'hC0_00_00, 1'b1, 1'b0, 1'b1);
    drive(24'h00_00_01, 1'b0, 1'b1, 1'b1);
    // de toggling every pixel
    for (int i = 0; i < 8; i++) drive($urandom, 1'b0, 1'b0, 1'(i % 2));
    // random lines
    for (int i = 0; i < 40; i++) line(1 + int'($urandom % 8), 1 + int'($urandom % 48));
    // drain with blanking
    repeat (24) drive($urandom, 1'($urandom), 1'($urandom), 1'b0);

    chk(rd + 4 >= wr, "R9", "pairs left behind", 64'(wr - rd), 64'd4);
    chk(rd > 200, "R7", "pairs delivered", 64'(rd), 64'd200);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule